// File: doc/BRIEF.md
# Prescaled Event Counter Unit

This block divides a stream of prescale ticks by a programmable ratio and counts the divided events. A tick enable arrives from outside at the prescale clock rate, which is nominally 20 MHz. Each tick moves a down-counter toward zero. On the tick after the down-counter has rested at zero, it refills from a software-set reload value, and the event counter advances by one. Events therefore occur once every reload+1 ticks.

Software reads and writes the three registers through a small register port. A two-bit select picks the register. Writes take effect at the next clock edge. Read data is the current value of the selected register, with no added latency. A reload value of zero is legal: the down-counter then stays at zero and the event counter advances on every tick. Generating the tick and decoding a bus address into the select are left to the surrounding logic.

Top module: `presc_event_unit`

## Requirements
- R1: After reset, the reload value, the down-count and the event count all read as zero.
- R2: On a clock edge with `tick_i` high, a nonzero down-count falls by one and the event count holds. With `tick_i` low and no write, both counters hold.
- R3: On a clock edge with `tick_i` high and the down-count at zero, the down-count takes the reload value and the event count rises by one on that same edge.
- R4: Starting from down-count c with reload r, after n ticks the event count has risen by floor((n-c+r)/(r+1)) for n > c, and by 0 otherwise. The down-count is then r - ((n-c+r) mod (r+1)) for n > c, and c-n otherwise.
- R5: With a reload value of zero, the down-count stays at zero once it gets there, and the event count rises on every tick.
- R6: Writing the reload value leaves the down-count unchanged. The new value is first used at the next refill. A refill on the same edge as a reload write uses the old reload value.
- R7: Writing the down-count or the event count sets that register to the written data on the next edge.
- R8: When a write and a tick hit the same register on one edge, the written value is stored and the tick has no effect on that register. The other counter still responds to the tick as in R2/R3, judged on the down-count held before the edge.
- R9: The event count wraps from all ones to zero, with no other effect.
- R10: Select encoding: 0 is the reload value, 1 is the down-count, 2 is the event count. Select 3 reads as zero, and writes to it change no register.
- R11: `rd_data_o` shows the selected register's current value combinationally, so a write is visible starting from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescale tick enable, one clock wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (R10 encoding) |
| wr_data_i | input | CNT_W | Write data |
| rd_data_o | output | CNT_W | Read data of the selected register |

## Verification
If the down-counter held a wrong value, the event count would advance on the wrong tick. That error shows up at the first read of the event count after the next refill, which is at most reload+1 ticks later. A wrong refill source or an off-by-one in zero detection changes the period itself, so the bench sweeps reload values, start counts and tick counts on a narrow instance and compares both counters against the closed-form result of R4. Faults in write precedence and refill timing show up one edge after the stimulus, and the bench reads them back at that point.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int unsigned DEF_CNT_W = 32;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_DOWN   = 2'd1,
        SEL_EVENT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/presc_wr_decode.sv
module presc_wr_decode
    import presc_pkg::*;
(
    input  logic       wr_en_i,
    input  logic [1:0] reg_sel_i,
    output logic       wr_reload_o,
    output logic       wr_down_o,
    output logic       wr_event_o
);

    localparam int unsigned N_SEL = 4;

    logic [N_SEL-1:0] hit;

    for (genvar g = 0; g < N_SEL; g++) begin : g_hit
        assign hit[g] = wr_en_i && (reg_sel_i == g[1:0]);
    end

    assign wr_reload_o = hit[SEL_RELOAD];
    assign wr_down_o   = hit[SEL_DOWN];
    assign wr_event_o  = hit[SEL_EVENT];

    logic unused_none;
    assign unused_none = hit[SEL_NONE];

endmodule

// File: rtl/presc_reload_reg.sv
module presc_reload_reg #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] reload_o
);

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } reload_st_t;

    reload_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.val = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.val;

endmodule

// File: rtl/presc_downcount.sv
module presc_downcount #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             refill_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } down_st_t;

    down_st_t st_d, st_q;
    logic     at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        if (wr_i) begin
            st_d.cnt = wr_data_i;
        end else if (tick_i) begin
            if (at_zero) begin
                st_d.cnt = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign refill_o = tick_i && at_zero;

endmodule

// File: rtl/presc_event_count.sv
module presc_event_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             refill_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cnt = wr_data_i;
        end else if (refill_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/presc_event_unit.sv
module presc_event_unit
    import presc_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       reg_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] rd_data_o
);

    logic             wr_reload, wr_down, wr_event;
    logic             refill;
    logic [CNT_W-1:0] reload_val, down_cnt, event_cnt;

    presc_wr_decode i_decode (
        .wr_en_i     (wr_en_i),
        .reg_sel_i   (reg_sel_i),
        .wr_reload_o (wr_reload),
        .wr_down_o   (wr_down),
        .wr_event_o  (wr_event)
    );

    presc_reload_reg #(.CNT_W(CNT_W)) i_reload (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_reload),
        .wr_data_i (wr_data_i),
        .reload_o  (reload_val)
    );

    presc_downcount #(.CNT_W(CNT_W)) i_down (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .wr_i      (wr_down),
        .wr_data_i (wr_data_i),
        .reload_i  (reload_val),
        .count_o   (down_cnt),
        .refill_o  (refill)
    );

    presc_event_count #(.CNT_W(CNT_W)) i_event (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .refill_i  (refill),
        .wr_i      (wr_event),
        .wr_data_i (wr_data_i),
        .count_o   (event_cnt)
    );

    always_comb begin
        unique case (reg_sel_i)
            SEL_RELOAD: rd_data_o = reload_val;
            SEL_DOWN:   rd_data_o = down_cnt;
            SEL_EVENT:  rd_data_o = event_cnt;
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/presc_event_unit_chk.sv
module presc_event_unit_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic [1:0]       reg_sel_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] down_q,
    input logic [CNT_W-1:0] event_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic wr_rl, wr_dn, wr_ev;
    assign wr_rl = wr_en_i && (reg_sel_i == 2'd0);
    assign wr_dn = wr_en_i && (reg_sel_i == 2'd1);
    assign wr_ev = wr_en_i && (reg_sel_i == 2'd2);

    AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_dn && down_q != '0) |=> (down_q == $past(down_q) - ONE)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_en_i) |=> ($stable(down_q) && $stable(event_q))); // R2

    AST_REFILL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_dn && down_q == '0) |=> (down_q == $past(reload_q))); // R3

    AST_EVENT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_ev && down_q == '0) |=> (event_q == $past(event_q) + ONE)); // R3

    AST_EVENT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_ev && down_q != '0) |=> $stable(event_q)); // R2

    AST_ZERO_STICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_q == '0 && down_q == '0 && !wr_dn) |=> (down_q == '0)); // R5

    AST_DOWN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_dn |=> (down_q == $past(wr_data_i))); // R8

    AST_EVENT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ev |=> (event_q == $past(wr_data_i))); // R7

    AST_RELOAD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_rl) |=> $stable(reload_q)); // R10

    AST_RELOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_rl |=> (reload_q == $past(wr_data_i))); // R6

endmodule

bind presc_event_unit presc_event_unit_chk #(.CNT_W(CNT_W)) i_presc_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .reg_sel_i (reg_sel_i),
    .wr_data_i (wr_data_i),
    .reload_q  (reload_val),
    .down_q    (down_cnt),
    .event_q   (event_cnt)
);

// File: tb/test_presc_event_unit.sv
module test_presc_event_unit;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    presc_event_unit #(.CNT_W(W)) i_presc_event_unit (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .reg_sel_i (sel),
        .wr_data_i (wdata),
        .rd_data_o (rdata)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
        @(negedge clk);
        sel = s;
        #1 d = rdata;
    endtask

    task automatic pulse(input int gap);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr_tick(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; sel = s; wdata = d; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic model(input int c, input int r, input int n, output int dn, output int inc);
        if (n <= c) begin
            dn = c - n; inc = 0;
        end else begin
            dn  = r - ((n - c + r) % (r + 1));
            inc = (n - c + r) / (r + 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int ed, ei;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(2'd0, v); check("R1 reload", v, 0);
        rd(2'd1, v); check("R1 down", v, 0);
        rd(2'd2, v); check("R1 event", v, 0);

        // R5 zero reload after reset: every tick counts, down stays 0
        pulse(0); pulse(1); pulse(0);
        rd(2'd1, v); check("R5 down stuck", v, 0);
        rd(2'd2, v); check("R5 event per tick", v, 3);

        // R2 no tick, no change
        wr(2'd1, 8'd6);
        repeat (5) @(negedge clk);
        rd(2'd1, v); check("R2 idle hold", v, 6);
        // R11 write visible next cycle
        rd(2'd2, v); check("R11 event readback", v, 3);

        // R6 reload write leaves down untouched
        wr(2'd0, 8'd3);
        rd(2'd1, v); check("R6 down unchanged", v, 6);
        rd(2'd0, v); check("R7 reload readback", v, 3);

        // R4 sweep
        for (int r = 0; r <= 5; r++) begin
            for (int c = 0; c <= 6; c++) begin
                for (int n = 0; n <= 13; n++) begin
                    wr(2'd0, W'(r));
                    wr(2'd1, W'(c));
                    wr(2'd2, 8'd0);
                    for (int k = 0; k < n; k++) pulse(k % 2);
                    model(c, r, n, ed, ei);
                    rd(2'd1, v); check("R4 down", v, W'(ed));
                    rd(2'd2, v); check("R4 event", v, W'(ei));
                end
            end
        end

        // R8 write beats tick on down-count
        wr(2'd1, 8'd5);
        wr(2'd2, 8'd0);
        wr_tick(2'd1, 8'd20);
        rd(2'd1, v); check("R8 down write wins", v, 20);
        rd(2'd2, v); check("R8 event untouched", v, 0);

        // R8 write beats tick on event; down still refills
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd7);
        wr_tick(2'd2, 8'd100);
        rd(2'd2, v); check("R8 event write wins", v, 100);
        rd(2'd1, v); check("R8 down refilled", v, 3);

        // R8 down written while at zero: event still counts
        wr(2'd1, 8'd0);
        wr_tick(2'd1, 8'd9);
        rd(2'd1, v); check("R8 down write at zero", v, 9);
        rd(2'd2, v); check("R8 event counts on zero", v, 101);

        // R6 refill on same edge as reload write uses old value
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd0);
        wr_tick(2'd0, 8'd6);
        rd(2'd1, v); check("R6 old reload used", v, 2);
        pulse(0); pulse(0);
        rd(2'd1, v); check("R3 reached zero", v, 0);
        pulse(0);
        rd(2'd1, v); check("R6 new reload used", v, 6);

        // R9 wrap
        wr(2'd1, 8'd0);
        wr(2'd2, 8'hFF);
        pulse(0);
        rd(2'd2, v); check("R9 event wrap", v, 0);

        // R10 select 3 ignored, reads zero
        wr(2'd0, 8'd11);
        wr(2'd1, 8'd22);
        wr(2'd2, 8'd33);
        wr(2'd3, 8'd99);
        rd(2'd3, v); check("R10 sel3 reads zero", v, 0);
        rd(2'd0, v); check("R10 reload intact", v, 11);
        rd(2'd1, v); check("R10 down intact", v, 22);
        rd(2'd2, v); check("R10 event intact", v, 33);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule